// File: doc/BRIEF.md
# Seconds Alarm Compare Unit

This block watches a free-running seconds count supplied from a slow time base. It fires an alarm event when that count reaches a programmed 48-bit value. Alarm events and one extra external event source are held as sticky status bits in the slow domain. Each bit has an enable, and the active-high, level-sensitive interrupt output is asserted while any enabled status bit is set. A small register interface with valid, write, address and data signals programs the alarm value and the enables. The same interface reads and clears the status.

The slow domain advances only on a one-cycle `slow_tick` strobe in the bus clock domain. A status clear written over the bus does two things. It removes the bit from the bus-side status copy at once. It also leaves a pending clear that reaches the slow-domain status only at the next tick, so the interrupt can stay high until that tick. A reload command copies the slow-domain status back into the bus-side copy, and software uses it to confirm that a clear has landed.

Top module: `alarm_compare_irq`

## Requirements
- R1: After reset the alarm value, the enables, both status copies and `irq` are all zero.
- R2: The alarm value is written as a low word at offset 0x20 (bits 31:0) and a high word at offset 0x24 (bits 15:0), and reads back from the same offsets, with bits 31:16 of 0x24 reading zero.
- R3: On a cycle with `slow_tick` high and `sec_count` equal to the full 48-bit alarm value, status bit 0 sets whatever the enable; without a tick, or when any bit differs, it does not set.
- R4: Writing 1 to bit n of offset 0x5C sets enable n, 0 bits leave enables unchanged, and reading 0x5C returns the enables in bits 1:0.
- R5: Writing 1 to bit n of offset 0x60 clears enable n.
- R6: `irq` is high exactly while some status bit is set with its enable set; offset 0x54 reads the bus-side status copy and offset 0x58 reads that copy ANDed with the enables.
- R7: Writing 1 to bit n of offset 0x58 clears bit n of the bus-side copy at once, but the slow-domain status, and so `irq`, clears only at the next `slow_tick`.
- R8: If a status bit is set by its event on the same tick at which a pending clear would apply, the bit stays set.
- R9: Writing 1 to bit 31 of offset 0x68 copies the slow-domain status into the bus-side copy; a write there with bit 31 low has no effect.
- R10: Status bit 1 sets on a tick where `alt_event` is high and follows the same enable, clear and interrupt rules as bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe marking a slow-clock edge |
| sec_count | input | 48 | Running seconds count from the time base |
| alt_event | input | 1 | Second event source, sampled on a tick |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level interrupt, active high |

## Verification
Two functions can fall in the same cycle: a new alarm match that sets status, and a status clear that lands at that tick. The bench provokes this by writing a status clear, so that the clear is pending, and then issuing a tick whose count equals the alarm value. The outcome counts as correct only if `irq` stays high and the bus copy reads 1 again. It also exercises the case where a clear stays pending without an event, which shows that the bus copy and the interrupt can disagree until the reload.

// File: rtl/alarm_pkg.sv
// Package: register offsets and field positions shared by the alarm unit.
// Assumes byte addressing with word-aligned registers.
package alarm_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFS_ALM_LO  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_ALM_HI  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_RAW     = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_STAT    = 8'h58;
    localparam logic [ADDR_W-1:0] OFS_EN_SET  = 8'h5C;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR  = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_RELOAD  = 8'h68;
endpackage

// File: rtl/alarm_regs.sv
// Module: register decode for the alarm unit. It holds the alarm value and the
// enables, produces clear and reload strobes, and muxes the read data.
// Assumes a single access per cycle; reads are combinational on bus_addr.
module alarm_regs
    import alarm_pkg::*;
#(
    parameter int CNT_W  = 48,
    parameter int DATA_W = 32,
    parameter int NSRC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NSRC-1:0]   copy_q,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  alarm_q,
    output logic [NSRC-1:0]   en_q,
    output logic [NSRC-1:0]   w1c_bits,
    output logic              reload_req
);
    localparam int HI_W = CNT_W - DATA_W;

    logic              wr;
    logic [NSRC-1:0]   set_bits, clr_bits;

    // Decode write strobes per register.
    always_comb begin
        wr         = bus_valid && bus_write;
        set_bits   = (wr && bus_addr == OFS_EN_SET) ? bus_wdata[NSRC-1:0] : '0;
        clr_bits   = (wr && bus_addr == OFS_EN_CLR) ? bus_wdata[NSRC-1:0] : '0;
        w1c_bits   = (wr && bus_addr == OFS_STAT)   ? bus_wdata[NSRC-1:0] : '0;
        reload_req = wr && bus_addr == OFS_RELOAD && bus_wdata[DATA_W-1];
    end

    // Hold the two alarm words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
        end else if (wr && bus_addr == OFS_ALM_LO) begin
            alarm_q[DATA_W-1:0] <= bus_wdata;
        end else if (wr && bus_addr == OFS_ALM_HI) begin
            alarm_q[CNT_W-1:DATA_W] <= bus_wdata[HI_W-1:0];
        end
    end

    // Update enables from the set and clear registers.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | set_bits) & ~clr_bits;
    end

    // Select read data by offset.
    always_comb begin
        unique case (bus_addr)
            OFS_ALM_LO: bus_rdata = alarm_q[DATA_W-1:0];
            OFS_ALM_HI: bus_rdata = {{(DATA_W-HI_W){1'b0}}, alarm_q[CNT_W-1:DATA_W]};
            OFS_RAW:    bus_rdata = {{(DATA_W-NSRC){1'b0}}, copy_q};
            OFS_STAT:   bus_rdata = {{(DATA_W-NSRC){1'b0}}, copy_q & en_q};
            OFS_EN_SET: bus_rdata = {{(DATA_W-NSRC){1'b0}}, en_q};
            default:    bus_rdata = '0;
        endcase
    end

    // R4: a set write leaves the enable high.
    a_r4_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_EN_SET && bus_wdata[0]) |=> en_q[0]);
    // R5: a clear write leaves the enable low.
    a_r5_enable_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_EN_CLR && bus_wdata[0]) |=> !en_q[0]);
endmodule

// File: rtl/alarm_slow.sv
// Module: slow-domain status. It compares the count with the alarm value and
// keeps sticky event bits that change only on slow_tick. A clear requested
// from the bus is held pending until the next tick, and a set beats that clear.
// Assumes slow_tick is a one-cycle strobe already synchronous to clk.
module alarm_slow #(
    parameter int CNT_W = 48,
    parameter int NSRC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic [CNT_W-1:0] sec_count,
    input  logic [CNT_W-1:0] alarm_q,
    input  logic [NSRC-2:0]  alt_event,
    input  logic [NSRC-1:0]  w1c_bits,
    output logic [NSRC-1:0]  evt_q,
    output logic [NSRC-1:0]  set_pulse
);
    logic [NSRC-1:0] src, clr_pend;

    // Gather event sources; bit 0 is the compare match.
    always_comb begin
        src       = {alt_event, sec_count == alarm_q};
        set_pulse = slow_tick ? src : '0;
    end

    // Hold clear requests until they reach a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)         clr_pend <= '0;
        else if (slow_tick) clr_pend <= w1c_bits;
        else                clr_pend <= clr_pend | w1c_bits;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_evt
        // Sticky event bit; a set has priority over a pending clear.
        always_ff @(posedge clk) begin
            if (!rst_n)         evt_q[i] <= 1'b0;
            else if (slow_tick) evt_q[i] <= src[i] | (evt_q[i] & ~clr_pend[i]);
        end
    end

    // R3: a matching tick leaves status bit 0 set.
    a_r3_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_tick && sec_count == alarm_q) |=> evt_q[0]);
    // R7: slow status never moves between ticks.
    a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_tick |=> $stable(evt_q));
    // R8: a match with a clear pending still leaves the bit set.
    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_tick && sec_count == alarm_q && clr_pend[0]) |=> evt_q[0]);
endmodule

// File: rtl/alarm_shadow.sv
// Module: bus-side status copy. New events set it at once, a write-one clear
// empties it at once, and a reload overwrites it with the slow-domain status.
// Assumes only one of clear or reload can occur per cycle.
module alarm_shadow #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_q,
    input  logic [NSRC-1:0] set_pulse,
    input  logic [NSRC-1:0] w1c_bits,
    input  logic            reload_req,
    output logic [NSRC-1:0] copy_q
);
    for (genvar i = 0; i < NSRC; i++) begin : g_copy
        // Track one status bit on the bus side.
        always_ff @(posedge clk) begin
            if (!rst_n)          copy_q[i] <= 1'b0;
            else if (reload_req) copy_q[i] <= evt_q[i] | set_pulse[i];
            else                 copy_q[i] <= (copy_q[i] & ~w1c_bits[i]) | set_pulse[i];
        end
    end

    // R9: a reload with no new event makes the copy equal the slow status.
    a_r9_reload_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_req && set_pulse == '0) |=> copy_q == $past(evt_q));
endmodule

// File: rtl/alarm_compare_irq.sv
// Module: top of the seconds alarm unit. It wires the register decode, the
// slow-domain status and the bus-side copy together and drives the interrupt.
// Assumes DATA_W is 32 and NSRC is at least 2.
module alarm_compare_irq #(
    parameter int CNT_W  = 48,
    parameter int DATA_W = 32,
    parameter int NSRC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic [CNT_W-1:0]  sec_count,
    input  logic              alt_event,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] alarm_q;
    logic [NSRC-1:0]  en_q, w1c_bits, evt_q, set_pulse, copy_q;
    logic             reload_req;

    alarm_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .NSRC(NSRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .copy_q(copy_q),
        .bus_rdata(bus_rdata), .alarm_q(alarm_q), .en_q(en_q),
        .w1c_bits(w1c_bits), .reload_req(reload_req)
    );

    alarm_slow #(.CNT_W(CNT_W), .NSRC(NSRC)) u_slow (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .sec_count(sec_count),
        .alarm_q(alarm_q), .alt_event({(NSRC-1){alt_event}}),
        .w1c_bits(w1c_bits), .evt_q(evt_q), .set_pulse(set_pulse)
    );

    alarm_shadow #(.NSRC(NSRC)) u_shadow (
        .clk(clk), .rst_n(rst_n), .evt_q(evt_q), .set_pulse(set_pulse),
        .w1c_bits(w1c_bits), .reload_req(reload_req), .copy_q(copy_q)
    );

    // Level interrupt from enabled slow-domain status.
    always_comb irq = |(evt_q & en_q);

    // R6: with every enable off the interrupt is low.
    a_r6_no_irq_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);
endmodule

// File: tb/tb_alarm_compare_irq.sv
module tb_alarm_compare_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic [47:0] sec_count = '0;
    logic        alt_event = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    alarm_compare_irq dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .sec_count(sec_count),
        .alt_event(alt_event), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Vector: write address, write data, read address, expected read data.
    localparam logic [79:0] TBL [0:6] = '{
        {8'h20, 32'hDEAD_BEEF, 8'h20, 32'hDEAD_BEEF},
        {8'h24, 32'hABCD_1234, 8'h24, 32'h0000_1234},
        {8'h5C, 32'h0000_0003, 8'h5C, 32'h0000_0003},
        {8'h60, 32'h0000_0001, 8'h5C, 32'h0000_0002},
        {8'h5C, 32'h0000_0000, 8'h5C, 32'h0000_0002},
        {8'h60, 32'h0000_0002, 8'h5C, 32'h0000_0000},
        {8'h24, 32'hFFFF_0000, 8'h24, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick(input logic [47:0] cnt, input logic alt);
        @(negedge clk);
        slow_tick = 1'b1; sec_count = cnt; alt_event = alt;
        @(negedge clk);
        slow_tick = 1'b0; alt_event = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        localparam logic [47:0] ALM = 48'h0001_2345_6789;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 irq", {31'b0, irq}, 0);
        rd(8'h54, r); check("R1 status copy", r, 0);
        rd(8'h5C, r); check("R1 enables", r, 0);
        rd(8'h20, r); check("R1 alarm lo", r, 0);

        // R2, R4, R5: register table
        for (int i = 0; i < 7; i++) begin
            wr(TBL[i][79:72], TBL[i][71:40]);
            rd(TBL[i][39:32], r);
            check($sformatf("R2/R4/R5 vector %0d", i), r, TBL[i][31:0]);
        end

        // R3: compare rules
        wr(8'h20, ALM[31:0]);
        wr(8'h24, {16'h0, ALM[47:32]});
        @(negedge clk); sec_count = ALM;
        repeat (3) @(negedge clk);
        rd(8'h54, r); check("R3 no set without tick", r, 0);
        tick(48'h0002_2345_6789, 1'b0);
        rd(8'h54, r); check("R3 high word differs", r, 0);
        tick(ALM, 1'b0);
        rd(8'h54, r); check("R3 set while disabled", r, 1);
        rd(8'h58, r); check("R6 masked while disabled", r, 0);
        check("R6 irq low while disabled", {31'b0, irq}, 0);

        // R6: enable exposes the interrupt
        wr(8'h5C, 32'h1);
        check("R6 irq high", {31'b0, irq}, 1);
        rd(8'h58, r); check("R6 masked status", r, 1);

        // R7: clear is immediate on bus copy, deferred on irq
        wr(8'h58, 32'h1);
        rd(8'h54, r); check("R7 copy cleared", r, 0);
        check("R7 irq held until tick", {31'b0, irq}, 1);
        tick(48'h5, 1'b0);
        check("R7 irq cleared at tick", {31'b0, irq}, 0);

        // R9: reload behaviour
        tick(ALM, 1'b0);
        wr(8'h58, 32'h1);
        wr(8'h68, 32'h0);
        rd(8'h54, r); check("R9 reload with bit31 low ignored", r, 0);
        wr(8'h68, 32'h8000_0000);
        rd(8'h54, r); check("R9 reload restores set bit", r, 1);

        // R8: set beats pending clear at the same tick
        wr(8'h58, 32'h1);
        tick(ALM, 1'b0);
        check("R8 irq stays high", {31'b0, irq}, 1);
        rd(8'h54, r); check("R8 copy set again", r, 1);

        // R9: after slow clear, copy stays until reload
        wr(8'h58, 32'h1);
        tick(48'h7, 1'b0);
        wr(8'h68, 32'h8000_0000);
        rd(8'h54, r); check("R9 reload shows cleared", r, 0);

        // R10: alternate source
        tick(48'h9, 1'b1);
        rd(8'h54, r); check("R10 alt raw", r, 2);
        check("R10 irq low, alt disabled", {31'b0, irq}, 0);
        wr(8'h5C, 32'h2);
        rd(8'h58, r); check("R10 alt masked", r, 2);
        check("R10 irq from alt", {31'b0, irq}, 1);
        wr(8'h60, 32'h2);
        check("R5 irq drops on disable", {31'b0, irq}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule